// File: doc/BRIEF.md
# Sinc Comparator Filter With Threshold Flags

This block is the fast protection path behind a delta-sigma modulator front end. It takes a one-bit stream, one bit per accepted beat, and runs it through a cascaded-integrator/comb decimator. The filter order is chosen at run time: first, second or third order sinc, or a fast mode. The fast mode is a second-order sinc whose decimation ratio is half the normal one, which gives lower latency at the cost of resolution. Each decimated result is clamped to 15 bits and published as a new sample.

Every new sample is compared against three 15-bit limits, and all three comparisons are inclusive. An over-value flag and an under-value flag can each raise an interrupt, and each has its own enable. A third crossing flag is meant for timing measurements of threshold crossings and never raises an interrupt. All limits, enables and the order and ratio settings must be held steady while reset is released and while the stream runs. A new configuration is applied by pulsing reset.

The input is a valid/ready stream. `in_ready` is held high, so the block never applies back-pressure, and every cycle with `in_valid` high delivers one bit. The output sample stream has no ready: `out_valid` is a single-cycle strobe, and the downstream logic must take the value in that cycle. The value and the flags then hold until the next strobe.

Top module: `sincf_cmp`

## Requirements
- R1: `in_ready` is high in every cycle, a bit is taken only in cycles with `in_valid` high, and `in_bit` is ignored when `in_valid` is low.
- R2: With a decimation ratio D, `out_valid` pulses for exactly one cycle, in the cycle after each D-th accepted bit counted from reset, and at no other time. D is `osr`+1 (0..31 maps to 1..32) for order codes 1, 2 and 3.
- R3: `order_sel` codes 1, 2 and 3 select sinc order N = 1, 2 or 3. The result is the N-fold nested sum of D consecutive bits, taken as a 0 or 1, ending at the D-th bit, with all bits before reset counted as zero.
- R4: `order_sel` code 0 selects the fast mode. It is a second-order result as in R3, with D = max(1, floor((`osr`+1)/2)).
- R5: A result above 32767 is published as 32767.
- R6: `over_flag` is set by a sample greater than or equal to `hi_lim`, and is cleared by any other sample.
- R7: `under_flag` is set by a sample less than or equal to `lo_lim`, and is cleared by any other sample.
- R8: `cross_flag` is set by a sample greater than or equal to `cross_lim`, and it never affects `irq`.
- R9: `irq` is a level, equal to (`over_flag` and `hi_irq_en`) or (`under_flag` and `lo_irq_en`).
- R10: While `rst_n` is low, `out_valid`, `out_value`, all three flags and `irq` are 0.
- R11: `out_value` and the three flags change only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream bit present this cycle |
| in_bit | input | 1 | Modulator bit |
| in_ready | output | 1 | Always high; no back-pressure |
| order_sel | input | 2 | 0 fast, 1 sinc1, 2 sinc2, 3 sinc3 |
| osr | input | 5 | Decimation setting, ratio = setting+1 |
| hi_lim | input | 15 | Over-value limit |
| lo_lim | input | 15 | Under-value limit |
| cross_lim | input | 15 | Crossing limit, no interrupt |
| hi_irq_en | input | 1 | Interrupt enable for over-value |
| lo_irq_en | input | 1 | Interrupt enable for under-value |
| out_valid | output | 1 | One-cycle strobe for a new sample |
| out_value | output | 15 | Clamped filter result |
| over_flag | output | 1 | Sample >= hi_lim |
| under_flag | output | 1 | Sample <= lo_lim |
| cross_flag | output | 1 | Sample >= cross_lim |
| irq | output | 1 | Enabled over/under condition |

## Verification
On every cycle, the assertions check three things. The decimation counter never passes the selected ratio. A sample strobe is always preceded by an accepted bit. The published value, the flags and the comb delay registers hold still between decimation points. The filtered values themselves, the clamp, the inclusive edges of each limit, the halved ratio of the fast mode and the interrupt gating can only be shown by the bench. It sweeps every order across a range of ratios with gapped pseudo-random streams, and compares each sample against nested window sums computed from the recorded bits.

// File: rtl/sincf_pkg.sv
package sincf_pkg;
  typedef enum logic [1:0] {
    ORD_FAST = 2'd0,
    ORD_S1   = 2'd1,
    ORD_S2   = 2'd2,
    ORD_S3   = 2'd3
  } sinc_order_e;

  localparam int MAX_ORDER = 3;
endpackage

// File: rtl/sincf_integ.sv
module sincf_integ #(
  parameter int STAGES = 3,
  parameter int W      = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       in_bit,
  output logic [STAGES-1:0][W-1:0]   nxt
);
  logic [STAGES-1:0][W-1:0] acc;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign nxt[g] = acc[g] + W'(in_bit);
    end else begin : g_rest
      assign nxt[g] = acc[g] + nxt[g-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)  acc[g] <= '0;
      else if (en) acc[g] <= nxt[g];
    end
  end
endmodule

// File: rtl/sincf_comb.sv
module sincf_comb #(
  parameter int STAGES = 3,
  parameter int W      = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [W-1:0]               din,
  output logic [STAGES-1:0][W-1:0]   dout
);
  logic [STAGES-1:0][W-1:0] src;
  logic [STAGES-1:0][W-1:0] dly;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign src[g] = din;
    end else begin : g_rest
      assign src[g] = dout[g-1];
    end

    assign dout[g] = src[g] - dly[g];

    always_ff @(posedge clk) begin
      if (!rst_n)  dly[g] <= '0;
      else if (en) dly[g] <= src[g];
    end
  end

  // R2: comb history moves only at decimation points
  assert_comb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dly));
endmodule

// File: rtl/sincf_limits.sv
module sincf_limits #(
  parameter int VAL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] val,
  input  logic [VAL_W-1:0] hi,
  input  logic [VAL_W-1:0] lo,
  input  logic [VAL_W-1:0] cr,
  output logic             over_q,
  output logic             under_q,
  output logic             cross_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
      cross_q <= 1'b0;
    end else if (load) begin
      over_q  <= (val >= hi);
      under_q <= (val <= lo);
      cross_q <= (val >= cr);
    end
  end

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({over_q, under_q, cross_q}));
endmodule

// File: rtl/sincf_cmp.sv
module sincf_cmp
  import sincf_pkg::*;
#(
  parameter int OSR_W = 5,
  parameter int VAL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  input  logic [1:0]       order_sel,
  input  logic [OSR_W-1:0] osr,
  input  logic [VAL_W-1:0] hi_lim,
  input  logic [VAL_W-1:0] lo_lim,
  input  logic [VAL_W-1:0] cross_lim,
  input  logic             hi_irq_en,
  input  logic             lo_irq_en,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_value,
  output logic             over_flag,
  output logic             under_flag,
  output logic             cross_flag,
  output logic             irq
);
  localparam int ACC_W = MAX_ORDER * OSR_W + 2;
  localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'((1 << VAL_W) - 1);

  sinc_order_e             ord;
  logic [1:0]              stage_idx;
  logic [OSR_W-1:0]        dec_last;
  logic [OSR_W-1:0]        cnt;
  logic                    beat;
  logic                    last;
  logic [MAX_ORDER-1:0][ACC_W-1:0] integ_nxt;
  logic [MAX_ORDER-1:0][ACC_W-1:0] comb_out;
  logic [ACC_W-1:0]        raw;
  logic [VAL_W-1:0]        sat;

  assign in_ready = 1'b1;
  assign beat     = in_valid;
  assign ord      = sinc_order_e'(order_sel);

  // Fast mode: second order with half the ratio, at least one
  always_comb begin
    if (ord == ORD_FAST) begin
      stage_idx = 2'd1;
      dec_last  = (osr == '0) ? '0 : ((osr - 1'b1) >> 1);
    end else begin
      stage_idx = order_sel - 2'd1;
      dec_last  = osr;
    end
  end

  assign last = beat && (cnt == dec_last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (last) cnt <= '0;
    else if (beat) cnt <= cnt + 1'b1;
  end

  sincf_integ #(.STAGES(MAX_ORDER), .W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .en(beat), .in_bit(in_bit), .nxt(integ_nxt)
  );

  sincf_comb #(.STAGES(MAX_ORDER), .W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .en(last), .din(integ_nxt[stage_idx]),
    .dout(comb_out)
  );

  assign raw = comb_out[stage_idx];
  assign sat = (raw > SAT_MAX) ? VAL_W'(SAT_MAX) : raw[VAL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= last;
      if (last) out_value <= sat;
    end
  end

  sincf_limits #(.VAL_W(VAL_W)) u_limits (
    .clk(clk), .rst_n(rst_n), .load(last), .val(sat),
    .hi(hi_lim), .lo(lo_lim), .cr(cross_lim),
    .over_q(over_flag), .under_q(under_flag), .cross_q(cross_flag)
  );

  assign irq = (over_flag && hi_irq_en) || (under_flag && lo_irq_en);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= dec_last);
  assert_strobe_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  assert_value_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_value));
endmodule

// File: tb/sincf_cmp_test.sv
`timescale 1ns/1ps
module sincf_cmp_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_ready;
  logic [1:0] order_sel = 2'd1;
  logic [4:0] osr = 5'd0;
  logic [14:0] hi_lim = '0, lo_lim = '0, cross_lim = '0;
  logic hi_irq_en = 1'b0, lo_irq_en = 1'b0;
  logic out_valid, over_flag, under_flag, cross_flag, irq;
  logic [14:0] out_value;

  sincf_cmp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .order_sel(order_sel), .osr(osr),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .cross_lim(cross_lim),
    .hi_irq_en(hi_irq_en), .lo_irq_en(lo_irq_en), .out_valid(out_valid),
    .out_value(out_value), .over_flag(over_flag), .under_flag(under_flag),
    .cross_flag(cross_flag), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit hist [0:8191];
  int nb = 0;
  bit beat_q = 1'b0;
  bit mon_en = 1'b0;
  int cfg_d = 1, cfg_n = 1;
  logic [15:0] lfsr = 16'hACE1;
  logic [14:0] pv = '0;
  logic po = 1'b0, pu = 1'b0, pc = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nest(input int idx, input int n, input int m);
    int s = 0;
    if (n == 0) return (idx >= 0) ? int'(hist[idx]) : 0;
    for (int a = 0; a < m; a++) s += nest(idx - a, n - 1, m);
    return s;
  endfunction

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  always @(posedge clk) begin
    beat_q = in_valid && rst_n;
    if (beat_q) begin
      hist[nb] = in_bit;
      nb++;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      int raw, ex;
      string tg;
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      ev = beat_q && (nb % cfg_d == 0);
      check(out_valid == ev, "R2 strobe", int'(out_valid), int'(ev));
      if (out_valid) begin
        raw = nest(nb - 1, cfg_n, cfg_d);
        ex = (raw > 32767) ? 32767 : raw;
        tg = (raw > 32767) ? "R5 clamp" : ((order_sel == 2'd0) ? "R4 fast" : "R3 sinc");
        check(int'(out_value) == ex, tg, int'(out_value), ex);
        check(over_flag == (ex >= int'(hi_lim)), "R6 over", int'(over_flag), int'(ex >= int'(hi_lim)));
        check(under_flag == (ex <= int'(lo_lim)), "R7 under", int'(under_flag), int'(ex <= int'(lo_lim)));
        check(cross_flag == (ex >= int'(cross_lim)), "R8 cross", int'(cross_flag), int'(ex >= int'(cross_lim)));
      end else begin
        check(out_value == pv && over_flag == po && under_flag == pu && cross_flag == pc,
              "R11 hold", int'(out_value), int'(pv));
      end
      check(irq == ((over_flag && hi_irq_en) || (under_flag && lo_irq_en)), "R9 R8 irq",
            int'(irq), int'((over_flag && hi_irq_en) || (under_flag && lo_irq_en)));
      pv = out_value; po = over_flag; pu = under_flag; pc = cross_flag;
    end
  end

  task automatic start(input int ord, input int ratio_set, input int h, input int l,
                       input int c, input bit he, input bit le);
    @(negedge clk);
    mon_en = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    order_sel = 2'(ord); osr = 5'(ratio_set);
    hi_lim = 15'(h); lo_lim = 15'(l); cross_lim = 15'(c);
    hi_irq_en = he; lo_irq_en = le;
    if (ord == 0) begin
      cfg_n = 2;
      cfg_d = (ratio_set + 1) / 2;
      if (cfg_d == 0) cfg_d = 1;
    end else begin
      cfg_n = ord;
      cfg_d = ratio_set + 1;
    end
    repeat (2) @(negedge clk);
    nb = 0;
    check(out_valid == 1'b0 && out_value == '0 && !over_flag && !under_flag &&
          !cross_flag && !irq, "R10 reset", int'(out_value), 0);
    pv = '0; po = 1'b0; pu = 1'b0; pc = 1'b0;
    mon_en = 1'b1;
    rst_n = 1'b1;
  endtask

  task automatic stream(input int beats, input bit ones);
    int taken = 0;
    while (taken < beats) begin
      @(negedge clk);
      in_valid = rnd() | rnd();
      in_bit = ones ? 1'b1 : rnd();
      if (!in_valid) in_bit = rnd();
      if (in_valid) taken++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_bit = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int osrs [7] = '{0, 1, 2, 4, 7, 12, 31};
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 7; k++) begin
        int d, n, mx;
        n = (o == 0) ? 2 : o;
        d = (o == 0) ? (((osrs[k] + 1) / 2 > 0) ? (osrs[k] + 1) / 2 : 1) : osrs[k] + 1;
        mx = d ** n;
        if (mx > 32767) mx = 32767;
        start(o, osrs[k], (mx * 2) / 3, mx / 3, mx / 2, k[0], !k[0]);
        stream(8 * d + 4, 1'b0);
      end
    end
    // R6 R7 R8 inclusive edges: sinc1 ratio 8, all ones settles at 8
    start(1, 7, 8, 8, 9, 1'b1, 1'b1);
    stream(20, 1'b1);
    check(over_flag && under_flag && !cross_flag, "R6 R7 R8 edge", int'(out_value), 8);
    // R5: sinc3 ratio 32, all ones reaches 32768
    start(3, 31, 32767, 0, 32767, 1'b1, 1'b0);
    stream(128, 1'b1);
    check(out_value == 15'd32767, "R5 saturate", int'(out_value), 32767);
    // R8: crossing alone leaves irq low
    start(1, 3, 10, 0, 2, 1'b1, 1'b1);
    stream(12, 1'b1);
    check(cross_flag && !irq, "R8 no irq", int'(irq), 0);
    mon_en = 1'b0;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule